// File: doc/BRIEF.md
# Masked Latching Alarm Controller

This block collects ten single-bit status events from a battery-protection style system and turns them into a latched alarm word and one active-low interrupt line. Seven of the events are plain levels: two protection-trip summaries, two early-warning summaries, two switch-off flags and a low-voltage shutdown flag. The other three behave differently. A startup-complete signal arrives as a one-cycle pulse. A debounced detector input raises an alarm whenever its level changes. An internal power-on flag is set by reset and is cleared by a configuration-exit strobe.

A host reaches the block through a small register port with one write strobe, a 2-bit address and a 10-bit data word. Reads are combinational. The host can read the live (unlatched) event word, read the latched word, and read or write the enable mask. It clears latched bits by writing ones to them. A latched bit is set only when its mask bit is set. While any latched bit is set, the interrupt pin is pulled low. It is modelled as an output enable with a data value that is always zero, as an open-drain pad would be.

The register port is a plain control and status interface with no valid/ready handshake. Every write completes in the cycle its strobe is high, and every read returns data in the same cycle, so there is no back-pressure.

Top module: `alarm_latch_ctrl`

## Requirements
- R1: The live word at address 0 reads, in the same cycle, `lvl_i[6:0]` on bits 6..0, `init_done_i` on bit 7, `det_level_i` on bit 8 and the power-on flag on bit 9. It stores nothing.
- R2: On a clock edge, a latched bit (address 1) can become set only if its mask bit (address 2) was set before that edge. An event whose mask bit is set appears in the latched word one cycle after it is sampled.
- R3: `alert_oe_o` is 1 exactly when the latched word is non-zero, and it is 0 during reset. `alert_do_o` is always 0.
- R4: A write to address 1 clears every latched bit whose data bit is 1. Latched bits whose data bit is 0 keep their value.
- R5: Reset loads the mask from parameter `DEFAULT_MASK` (default 10'h3BF, which masks only bit 6). A write to address 2 replaces the mask, and address 2 reads it back.
- R6: A one-cycle pulse on `init_done_i`, when bit 7 is enabled, sets latched bit 7. The bit stays set until the host clears it.
- R7: Latched bit 8 is set when `det_level_i` differs from a stored reference level and bit 8 is enabled. The reference resets to 0 and takes the current detector level whenever bit 8 is set, so each change latches once. A difference that occurs while bit 8 is masked latches when the bit is unmasked.
- R8: The power-on flag (live bit 9) is 1 after reset. It is 0 from the cycle after a `cfg_exit_i` strobe onward.
- R9: If a host clear and a set request hit the same bit in the same cycle, the set wins. The bit stays set and the alert stays asserted.
- R10: Writes to address 0 or 3 change nothing, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_i | input | 7 | Level events (trip A/B, warning A/B, charge-off, discharge-off, low voltage) |
| init_done_i | input | 1 | One-cycle startup-complete pulse |
| det_level_i | input | 1 | Debounced detector level |
| cfg_exit_i | input | 1 | Configuration-exit strobe; clears the power-on flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 live, 1 latched, 2 mask |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 10 | Read data for `reg_addr_i` |
| alert_oe_o | output | 1 | Interrupt pull-down enable (1 = pin driven low) |
| alert_do_o | output | 1 | Interrupt pad data, constant 0 |

## Verification
The latching path is exercised with the following patterns:
- Single and multiple level events arriving with their mask bits set and with them cleared. These separate a working mask from a mask that is ignored.
- Clears that land while the matching event is still high. These separate set-wins priority from clear-wins priority.
- Write-one-to-clear words that contain zeros. These show whether untouched bits are left alone.
- A lone startup pulse followed by idle cycles. This shows whether the bit is truly held.
- Detector rises, falls, clears at a steady level, and a change made while the bit is masked. These separate edge-style toggle detection from level latching and show whether the reference level updates at the right time.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic [1:0] {
    ADR_LIVE  = 2'd0,
    ADR_LATCH = 2'd1,
    ADR_MASK  = 2'd2,
    ADR_NONE  = 2'd3
  } alarm_adr_e;
endpackage

// File: rtl/alarm_event_gather.sv
module alarm_event_gather #(
  parameter int LVL_W = 7,
  localparam int EVT_W = LVL_W + 3,
  localparam int INIT_B = LVL_W,
  localparam int DET_B = LVL_W + 1,
  localparam int POR_B = LVL_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             init_i,
  input  logic             det_i,
  input  logic             cfg_exit_i,
  input  logic             det_ack_i,
  output logic [EVT_W-1:0] raw_o,
  output logic [EVT_W-1:0] trig_o
);
  logic por_q;
  logic det_ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_q <= 1'b1;
    else if (cfg_exit_i) por_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det_ref_q <= 1'b0;
    else if (det_ack_i) det_ref_q <= det_i;
  end

  always_comb begin
    raw_o = {por_q, det_i, init_i, lvl_i};
    trig_o = raw_o;
    trig_o[DET_B] = det_i ^ det_ref_q;
  end

  p_por_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_exit_i |=> !raw_o[POR_B]);

  p_ref_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det_ack_i |=> (det_ref_q == $past(det_i)));

  p_init_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    raw_o[INIT_B] == init_i);
endmodule

// File: rtl/alarm_latch_bank.sv
module alarm_latch_bank #(
  parameter int EVT_W = 10,
  parameter int INIT_B = 7,
  parameter logic [EVT_W-1:0] DEFAULT_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] trig_i,
  input  logic [EVT_W-1:0] clr_i,
  input  logic             mask_wr_i,
  input  logic [EVT_W-1:0] mask_wdata_i,
  output logic [EVT_W-1:0] lat_o,
  output logic [EVT_W-1:0] mask_o,
  output logic [EVT_W-1:0] set_o
);
  logic [EVT_W-1:0] lat_q;
  logic [EVT_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= DEFAULT_MASK;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  for (genvar b = 0; b < EVT_W; b++) begin : g_bit
    assign set_o[b] = mask_q[b] & trig_i[b];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q[b] <= 1'b0;
      else lat_q[b] <= set_o[b] | (lat_q[b] & ~clr_i[b]);
    end
  end

  assign lat_o = lat_q;
  assign mask_o = mask_q;

  p_masked_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & ~$past(lat_q) & ~$past(mask_q)) == '0));

  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(clr_i) & ~$past(set_o)) == '0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(set_o)) == $past(set_o)));

  p_init_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[INIT_B] && !clr_i[INIT_B]) |=> lat_q[INIT_B]);
endmodule

// File: rtl/alarm_host_port.sv
module alarm_host_port
  import alarm_pkg::*;
#(
  parameter int EVT_W = 10
) (
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [EVT_W-1:0] wdata_i,
  input  logic [EVT_W-1:0] raw_i,
  input  logic [EVT_W-1:0] lat_i,
  input  logic [EVT_W-1:0] mask_i,
  output logic [EVT_W-1:0] clr_o,
  output logic             mask_wr_o,
  output logic [EVT_W-1:0] rdata_o
);
  alarm_adr_e adr;
  assign adr = alarm_adr_e'(addr_i);

  assign clr_o = (wr_i && adr == ADR_LATCH) ? wdata_i : '0;
  assign mask_wr_o = wr_i && (adr == ADR_MASK);

  always_comb begin
    unique case (adr)
      ADR_LIVE:  rdata_o = raw_i;
      ADR_LATCH: rdata_o = lat_i;
      ADR_MASK:  rdata_o = mask_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/alarm_latch_ctrl.sv
module alarm_latch_ctrl #(
  parameter int LVL_W = 7,
  localparam int EVT_W = LVL_W + 3,
  parameter logic [EVT_W-1:0] DEFAULT_MASK = 10'h3BF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             init_done_i,
  input  logic             det_level_i,
  input  logic             cfg_exit_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [EVT_W-1:0] reg_wdata_i,
  output logic [EVT_W-1:0] reg_rdata_o,
  output logic             alert_oe_o,
  output logic             alert_do_o
);
  localparam int INIT_B = LVL_W;
  localparam int DET_B = LVL_W + 1;

  logic [EVT_W-1:0] raw, trig, lat, mask, set, clr;
  logic mask_wr;

  alarm_event_gather #(.LVL_W(LVL_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .init_i(init_done_i),
    .det_i(det_level_i), .cfg_exit_i(cfg_exit_i), .det_ack_i(set[DET_B]),
    .raw_o(raw), .trig_o(trig)
  );

  alarm_latch_bank #(.EVT_W(EVT_W), .INIT_B(INIT_B), .DEFAULT_MASK(DEFAULT_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .clr_i(clr),
    .mask_wr_i(mask_wr), .mask_wdata_i(reg_wdata_i),
    .lat_o(lat), .mask_o(mask), .set_o(set)
  );

  alarm_host_port #(.EVT_W(EVT_W)) u_port (
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .raw_i(raw), .lat_i(lat), .mask_i(mask),
    .clr_o(clr), .mask_wr_o(mask_wr), .rdata_o(reg_rdata_o)
  );

  assign alert_oe_o = |lat;
  assign alert_do_o = 1'b0;

  p_alert_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_oe_o && set == '0) |=> !alert_oe_o);

  p_alert_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_oe_o && clr == '0) |=> alert_oe_o);

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_do_o);
endmodule

// File: tb/test_alarm_latch_ctrl.sv
module test_alarm_latch_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 20;
  // [31:25] lvl, [24] init, [23] det, [22] wr, [21:20] addr, [19:10] wdata, [9:0] expected latched
  localparam logic [31:0] VECS [0:NV-1] = '{
    {7'h01, 1'b0, 1'b0, 1'b0, 2'd0, 10'h000, 10'h001},
    {7'h00, 1'b0, 1'b0, 1'b1, 2'd1, 10'h001, 10'h000},
    {7'h40, 1'b0, 1'b0, 1'b0, 2'd0, 10'h000, 10'h000},
    {7'h0A, 1'b0, 1'b0, 1'b0, 2'd0, 10'h000, 10'h00A},
    {7'h08, 1'b0, 1'b0, 1'b1, 2'd1, 10'h00A, 10'h008},
    {7'h00, 1'b0, 1'b0, 1'b1, 2'd1, 10'h000, 10'h008},
    {7'h00, 1'b0, 1'b0, 1'b1, 2'd1, 10'h3FF, 10'h000},
    {7'h00, 1'b1, 1'b0, 1'b0, 2'd0, 10'h000, 10'h080},
    {7'h00, 1'b0, 1'b0, 1'b0, 2'd0, 10'h000, 10'h080},
    {7'h00, 1'b0, 1'b0, 1'b1, 2'd2, 10'h3FF, 10'h080},
    {7'h40, 1'b0, 1'b0, 1'b0, 2'd0, 10'h000, 10'h0C0},
    {7'h00, 1'b0, 1'b1, 1'b0, 2'd0, 10'h000, 10'h1C0},
    {7'h00, 1'b0, 1'b1, 1'b1, 2'd1, 10'h100, 10'h0C0},
    {7'h00, 1'b0, 1'b0, 1'b1, 2'd1, 10'h0C0, 10'h100},
    {7'h00, 1'b0, 1'b0, 1'b1, 2'd1, 10'h100, 10'h000},
    {7'h00, 1'b0, 1'b0, 1'b1, 2'd0, 10'h3FF, 10'h000},
    {7'h00, 1'b0, 1'b0, 1'b1, 2'd2, 10'h000, 10'h000},
    {7'h7F, 1'b1, 1'b1, 1'b0, 2'd0, 10'h000, 10'h000},
    {7'h00, 1'b0, 1'b1, 1'b1, 2'd2, 10'h100, 10'h000},
    {7'h00, 1'b0, 1'b1, 1'b0, 2'd0, 10'h000, 10'h100}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] lvl = '0;
  logic init_done = 1'b0, det = 1'b0, cfg_exit = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [9:0] wdata = '0;
  logic [9:0] rdata;
  logic alert_oe, alert_do;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_latch_ctrl i_alarm_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .init_done_i(init_done),
    .det_level_i(det), .cfg_exit_i(cfg_exit), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .alert_oe_o(alert_oe), .alert_do_o(alert_do)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [1:0] a, input string req, input logic [9:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lvl = '0; init_done = 1'b0; det = 1'b0; cfg_exit = 1'b0;
    wr = 1'b0; addr = 2'd1; wdata = '0;
    repeat (3) tick();
    chk("R3 reset alert", {9'd0, alert_oe}, 10'h000);
    read_at(2'd1, "R3 reset latched", 10'h000);
    rst_n = 1'b1;
    read_at(2'd2, "R5 default mask", 10'h3BF);
    read_at(2'd0, "R8 power-on flag set", 10'h200);
    addr = 2'd1;
    tick();
    read_at(2'd1, "R2 power-on latched", 10'h200);
    chk("R3 alert asserted", {8'd0, alert_do, alert_oe}, 10'h001);
  endtask

  initial begin
    do_reset();
    cfg_exit = 1'b1;
    tick();
    cfg_exit = 1'b0;
    read_at(2'd0, "R8 flag cleared by strobe", 10'h000);
    tick();
    read_at(2'd0, "R8 flag stays clear", 10'h000);
    wr = 1'b1; addr = 2'd1; wdata = 10'h200;
    tick();
    wr = 1'b0;
    read_at(2'd1, "R4 clear power-on bit", 10'h000);
    chk("R3 alert released", {9'd0, alert_oe}, 10'h000);

    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      v = VECS[k];
      lvl = v[31:25]; init_done = v[24]; det = v[23];
      wr = v[22]; addr = v[21:20]; wdata = v[19:10];
      tick();
      init_done = 1'b0; wr = 1'b0; addr = 2'd1;
      #1;
      // vector walk covers R2 R4 R6 R7 R9 R10
      chk($sformatf("R2/R4/R6/R7/R9 vector %0d latched", k), rdata, v[9:0]);
      chk($sformatf("R3 vector %0d alert", k), {9'd0, alert_oe}, {9'd0, v[9:0] != 10'h000});
      tick();
    end

    // directed: live word and read map
    lvl = 7'h55; det = 1'b1;
    read_at(2'd0, "R1 live word", 10'h155);
    init_done = 1'b1;
    read_at(2'd0, "R1 live init pulse", 10'h1D5);
    init_done = 1'b0;
    read_at(2'd2, "R5 mask readback", 10'h100);
    read_at(2'd3, "R10 unused address reads zero", 10'h000);
    wr = 1'b1; addr = 2'd3; wdata = 10'h3FF;
    tick();
    wr = 1'b0;
    read_at(2'd2, "R10 write to address 3 leaves mask", 10'h100);
    read_at(2'd1, "R10 write to address 3 leaves latched", 10'h100);

    // second reset restores mask and power-on flag
    do_reset();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule